// File: doc/BRIEF.md
# Cache Way Partition Allocation Selector

This block picks the way of a shared last-level cache that receives a new line when a miss is allocated. It does not pick by requester. The miss address is first decoded against a small set of power-of-two address windows, and the matching window supplies a domain ID. That ID, together with the transaction type, is then checked against a table of partition entries. Each entry carries an ID mask, a type mask and a way mask. The way masks of every entry that admits the miss are merged. A per-set round-robin pointer then walks that merged mask to name the victim way.

Software programs windows and partition entries through a single register write port. Cache control presents each miss as an address plus a type. One clock later the block answers with either a victim way or a no-allocate indication. Two cores that touch the same address range land in the same partition. Separation between agents comes only from giving them disjoint address ranges.

Top module: `way_part_alloc`

## Requirements
- R1: After reset every window is disabled, so every miss gets no-allocate until a window is enabled.
- R2: A window matches when it is enabled and the address equals its base in all bits at or above its size exponent (window ctrl word: bit 31 enable, bits 12:8 size exponent, bits 4:0 domain ID).
- R3: When several enabled windows match, the lowest-numbered one supplies the domain ID.
- R4: A miss that matches no enabled window produces no-allocate and no victim.
- R5: A partition entry admits a miss only when bit `domain ID` of its ID mask and bit `type` of its type mask (3-bit type, 8-bit mask) are both set.
- R6: The allowed ways are the OR of the way masks of all admitting entries, and the reported victim always lies inside that set.
- R7: If the merged way mask is all zero, the miss produces no-allocate and no victim.
- R8: Each set (address bits 9:6) has its own pointer, reset to way 0. The victim is the first allowed way at or above the pointer, wrapping from way 31 to way 0, and the pointer then moves to victim+1. A miss that allocates nothing leaves the pointer unchanged.
- R9: Victim valid, victim way and no-allocate are registered and appear exactly one clock after the miss. Without a miss, both victim valid and no-allocate are low.
- R10: Config address bit 6 selects windows (1) or partition entries (0). Entry index is bits 5:2 and window index is bits 4:2. Bits 1:0 select the field: 0 = ID mask, 1 = type mask, 2 = way mask for entries, and 0 = base, 1 = ctrl for windows. Other field codes are ignored. A write made in the same cycle as a miss affects only later misses.
- R11: After reset every partition entry has its ID, type and way masks all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | 32 | Miss physical address |
| miss_type_i | input | 3 | Miss transaction type |
| victim_valid_o | output | 1 | A victim way was chosen |
| victim_way_o | output | 5 | Chosen victim way |
| no_alloc_o | output | 1 | Miss proceeds without allocating |

## Verification
The bench programs overlapping windows to show that the lowest index wins. A design with a reversed priority would allocate into the higher window's ways. It uses types that are admitted by one entry but not by another, and a merged mask that is empty. A design that ignored the type mask or misread an empty mask would return a victim where none is allowed. It drives misses into several sets and lets sparse masks wrap past way 31, so a shared pointer or a pointer that moves on no-allocate shows up as a wrong way. A config write that lands in the same cycle as a miss must leave that miss on the old settings.

// File: rtl/way_part_pkg.sv
package way_part_pkg;
  localparam int ADDR_W   = 32;
  localparam int NUM_WAYS = 32;
  localparam int NUM_WIN  = 8;
  localparam int NUM_PART = 16;
  localparam int ID_W     = 5;
  localparam int TYPE_W   = 3;
  localparam int SET_BITS = 4;
  localparam int LINE_OFF = 6;
  localparam int CFG_AW   = 7;
  localparam int CFG_DW   = 32;

  typedef enum logic [1:0] {
    FLD_ID   = 2'd0,
    FLD_TYPE = 2'd1,
    FLD_WAY  = 2'd2,
    FLD_RSVD = 2'd3
  } part_fld_e;

  typedef enum logic [1:0] {
    WFLD_BASE = 2'd0,
    WFLD_CTRL = 2'd1
  } win_fld_e;
endpackage

// File: rtl/wp_window_decode.sv
module wp_window_decode #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 8,
  parameter int ID_W    = 5,
  parameter int SZ_W    = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              win_en_i   [NUM_WIN],
  input  logic [ADDR_W-1:0] win_base_i [NUM_WIN],
  input  logic [SZ_W-1:0]   win_sz_i   [NUM_WIN],
  input  logic [ID_W-1:0]   win_id_i   [NUM_WIN],
  output logic              hit_o,
  output logic [ID_W-1:0]   id_o
);
  logic [NUM_WIN-1:0] match;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] cmp_mask;
    assign cmp_mask   = {ADDR_W{1'b1}} << win_sz_i[w];
    assign match[w]   = win_en_i[w] && (((addr_i ^ win_base_i[w]) & cmp_mask) == '0);
  end

  // descending scan: lowest index wins
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_o = 1'b1;
        id_o  = win_id_i[w];
      end
    end
  end
endmodule

// File: rtl/wp_partition_match.sv
module wp_partition_match #(
  parameter int NUM_PART = 16,
  parameter int ID_W     = 5,
  parameter int TYPE_W   = 3,
  parameter int NUM_WAYS = 32,
  localparam int NUM_IDS   = 1 << ID_W,
  localparam int NUM_TYPES = 1 << TYPE_W
) (
  input  logic [ID_W-1:0]      id_i,
  input  logic [TYPE_W-1:0]    type_i,
  input  logic [NUM_IDS-1:0]   id_mask_i   [NUM_PART],
  input  logic [NUM_TYPES-1:0] type_mask_i [NUM_PART],
  input  logic [NUM_WAYS-1:0]  way_mask_i  [NUM_PART],
  output logic [NUM_WAYS-1:0]  way_mask_o
);
  logic [NUM_PART-1:0] permit;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    assign permit[p] = id_mask_i[p][id_i] && type_mask_i[p][type_i];
  end

  always_comb begin
    way_mask_o = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (permit[p]) way_mask_o = way_mask_o | way_mask_i[p];
    end
  end
endmodule

// File: rtl/wp_rr_victim.sv
module wp_rr_victim #(
  parameter int NUM_WAYS = 32,
  parameter int SET_BITS = 4,
  localparam int WAY_IDX_W = $clog2(NUM_WAYS),
  localparam int NUM_SETS  = 1 << SET_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pick_i,
  input  logic [SET_BITS-1:0]  set_i,
  input  logic [NUM_WAYS-1:0]  mask_i,
  output logic                 any_o,
  output logic [WAY_IDX_W-1:0] way_o
);
  logic [NUM_SETS-1:0][WAY_IDX_W-1:0] ptr_q;
  logic [WAY_IDX_W-1:0]  ptr_cur;
  logic [2*NUM_WAYS-1:0] dbl;
  logic [NUM_WAYS-1:0]   rot;
  logic [WAY_IDX_W-1:0]  off;
  logic [WAY_IDX_W:0]    sum;

  assign ptr_cur = ptr_q[set_i];
  assign any_o   = |mask_i;
  assign dbl     = {mask_i, mask_i} >> ptr_cur;
  assign rot     = dbl[NUM_WAYS-1:0];

  always_comb begin
    off = '0;
    for (int k = NUM_WAYS - 1; k >= 0; k--) begin
      if (rot[k]) off = WAY_IDX_W'(k);
    end
  end

  // NUM_WAYS is a power of two, so the carry drops out as the wrap
  assign sum   = {1'b0, ptr_cur} + {1'b0, off};
  assign way_o = sum[WAY_IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (pick_i && any_o) ptr_q[set_i] <= way_o + WAY_IDX_W'(1);
  end

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pick_i && any_o) |=> $stable(ptr_q));

  assert_one_ptr_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_i && any_o) |=> ($countones(ptr_q ^ $past(ptr_q)) <= WAY_IDX_W));
endmodule

// File: rtl/way_part_alloc.sv
module way_part_alloc
  import way_part_pkg::*;
#(
  parameter int P_ADDR_W   = ADDR_W,
  parameter int P_NUM_WAYS = NUM_WAYS,
  parameter int P_NUM_WIN  = NUM_WIN,
  parameter int P_NUM_PART = NUM_PART,
  parameter int P_ID_W     = ID_W,
  parameter int P_TYPE_W   = TYPE_W,
  parameter int P_SET_BITS = SET_BITS,
  parameter int P_LINE_OFF = LINE_OFF,
  parameter int P_CFG_AW   = CFG_AW,
  parameter int P_CFG_DW   = CFG_DW,
  localparam int WAY_IDX_W = $clog2(P_NUM_WAYS),
  localparam int SZ_W      = $clog2(P_ADDR_W),
  localparam int NUM_IDS   = 1 << P_ID_W,
  localparam int NUM_TYPES = 1 << P_TYPE_W,
  localparam int PSEL_W    = $clog2(P_NUM_PART),
  localparam int WSEL_W    = $clog2(P_NUM_WIN),
  localparam int SZ_LSB    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [P_CFG_AW-1:0]   cfg_addr_i,
  input  logic [P_CFG_DW-1:0]   cfg_wdata_i,
  input  logic                  miss_valid_i,
  input  logic [P_ADDR_W-1:0]   miss_addr_i,
  input  logic [P_TYPE_W-1:0]   miss_type_i,
  output logic                  victim_valid_o,
  output logic [WAY_IDX_W-1:0]  victim_way_o,
  output logic                  no_alloc_o
);
  logic                  win_en   [P_NUM_WIN];
  logic [P_ADDR_W-1:0]   win_base [P_NUM_WIN];
  logic [SZ_W-1:0]       win_sz   [P_NUM_WIN];
  logic [P_ID_W-1:0]     win_id   [P_NUM_WIN];
  logic [NUM_IDS-1:0]    id_mask   [P_NUM_PART];
  logic [NUM_TYPES-1:0]  type_mask [P_NUM_PART];
  logic [P_NUM_WAYS-1:0] way_mask  [P_NUM_PART];

  logic                  is_win_reg;
  logic [1:0]            fld;
  logic [PSEL_W-1:0]     part_sel;
  logic [WSEL_W-1:0]     win_sel;
  logic                  unused_cfg;

  assign is_win_reg = cfg_addr_i[P_CFG_AW-1];
  assign fld        = cfg_addr_i[1:0];
  assign part_sel   = cfg_addr_i[2 +: PSEL_W];
  assign win_sel    = cfg_addr_i[2 +: WSEL_W];
  assign unused_cfg = ^{cfg_wdata_i[30:SZ_LSB+SZ_W], cfg_wdata_i[SZ_LSB-1:P_ID_W]};

  for (genvar w = 0; w < P_NUM_WIN; w++) begin : g_win_reg
    logic wr;
    assign wr = cfg_we_i && is_win_reg && (win_sel == WSEL_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_en[w]   <= 1'b0;
        win_base[w] <= '0;
        win_sz[w]   <= '0;
        win_id[w]   <= '0;
      end else if (wr) begin
        if (fld == WFLD_BASE) win_base[w] <= cfg_wdata_i[P_ADDR_W-1:0];
        if (fld == WFLD_CTRL) begin
          win_en[w] <= cfg_wdata_i[P_CFG_DW-1];
          win_sz[w] <= cfg_wdata_i[SZ_LSB +: SZ_W];
          win_id[w] <= cfg_wdata_i[0 +: P_ID_W];
        end
      end
    end
  end

  for (genvar p = 0; p < P_NUM_PART; p++) begin : g_part_reg
    logic wr;
    assign wr = cfg_we_i && !is_win_reg && (part_sel == PSEL_W'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_mask[p]   <= '1;
        type_mask[p] <= '1;
        way_mask[p]  <= '1;
      end else if (wr) begin
        case (part_fld_e'(fld))
          FLD_ID:   id_mask[p]   <= cfg_wdata_i[NUM_IDS-1:0];
          FLD_TYPE: type_mask[p] <= cfg_wdata_i[NUM_TYPES-1:0];
          FLD_WAY:  way_mask[p]  <= cfg_wdata_i[P_NUM_WAYS-1:0];
          default: ;
        endcase
      end
    end
  end

  logic                  win_hit;
  logic [P_ID_W-1:0]     dom_id;
  logic [P_NUM_WAYS-1:0] part_mask;
  logic [P_NUM_WAYS-1:0] eff_mask;
  logic                  rr_any;
  logic [WAY_IDX_W-1:0]  rr_way;
  logic                  do_alloc;

  wp_window_decode #(
    .ADDR_W(P_ADDR_W), .NUM_WIN(P_NUM_WIN), .ID_W(P_ID_W), .SZ_W(SZ_W)
  ) u_win (
    .addr_i(miss_addr_i), .win_en_i(win_en), .win_base_i(win_base),
    .win_sz_i(win_sz), .win_id_i(win_id), .hit_o(win_hit), .id_o(dom_id)
  );

  wp_partition_match #(
    .NUM_PART(P_NUM_PART), .ID_W(P_ID_W), .TYPE_W(P_TYPE_W), .NUM_WAYS(P_NUM_WAYS)
  ) u_match (
    .id_i(dom_id), .type_i(miss_type_i), .id_mask_i(id_mask),
    .type_mask_i(type_mask), .way_mask_i(way_mask), .way_mask_o(part_mask)
  );

  assign eff_mask = win_hit ? part_mask : '0;

  wp_rr_victim #(
    .NUM_WAYS(P_NUM_WAYS), .SET_BITS(P_SET_BITS)
  ) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .pick_i(miss_valid_i),
    .set_i(miss_addr_i[P_LINE_OFF +: P_SET_BITS]), .mask_i(eff_mask),
    .any_o(rr_any), .way_o(rr_way)
  );

  assign do_alloc = miss_valid_i && rr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      no_alloc_o     <= 1'b0;
      victim_way_o   <= '0;
    end else begin
      victim_valid_o <= do_alloc;
      no_alloc_o     <= miss_valid_i && !rr_any;
      if (do_alloc) victim_way_o <= rr_way;
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> (victim_valid_o ^ no_alloc_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> (!victim_valid_o && !no_alloc_o));

  assert_no_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !win_hit) |=> no_alloc_o);

  assert_empty_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && (part_mask == '0)) |=> no_alloc_o);

  assert_way_in_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && win_hit) |=> (!victim_valid_o ||
      ((($past(part_mask) >> victim_way_o) & P_NUM_WAYS'(1)) != '0)));
endmodule

// File: tb/tb_way_part_alloc.sv
`timescale 1ns/1ps
module tb_way_part_alloc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        miss_valid_i = 1'b0;
  logic [31:0] miss_addr_i = '0;
  logic [2:0]  miss_type_i = '0;
  logic        victim_valid_o;
  logic [4:0]  victim_way_o;
  logic        no_alloc_o;

  always #2 clk = ~clk;

  way_part_alloc dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
    .miss_type_i(miss_type_i), .victim_valid_o(victim_valid_o),
    .victim_way_o(victim_way_o), .no_alloc_o(no_alloc_o)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit [31:0] m_base[8];
  int        m_sz[8];
  bit        m_en[8];
  int        m_id[8];
  bit [31:0] m_idm[16];
  bit [7:0]  m_typ[16];
  bit [31:0] m_way[16];
  int        m_ptr[16];

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_sz[i] = 0; m_en[i] = 0; m_id[i] = 0; end
    for (int i = 0; i < 16; i++) begin
      m_idm[i] = '1; m_typ[i] = '1; m_way[i] = '1; m_ptr[i] = 0;
    end
  endtask

  function automatic bit [6:0] pa(int e, int f);
    return {1'b0, 4'(e), 2'(f)};
  endfunction
  function automatic bit [6:0] wa(int w, int f);
    return {2'b10, 3'(w), 2'(f)};
  endfunction
  function automatic bit [31:0] wctrl(bit en, int sz, int id);
    return {en, 18'd0, 5'(sz), 3'd0, 5'(id)};
  endfunction

  // one cycle: drive, predict, step, compare at the following negedge
  task automatic cyc(string tag, bit we, bit [6:0] ca, bit [31:0] cd,
                     bit mv, bit [31:0] ma, bit [2:0] mt);
    bit ev, en;
    int ew;
    int id;
    bit hit;
    bit [31:0] msk;
    int s;
    cfg_we_i = we; cfg_addr_i = ca; cfg_wdata_i = cd;
    miss_valid_i = mv; miss_addr_i = ma; miss_type_i = mt;
    ev = 0; en = 0; ew = -1;
    if (mv) begin
      hit = 0; id = 0;
      for (int w = 0; w < 8 && !hit; w++)
        if (m_en[w] && ((ma >> m_sz[w]) == (m_base[w] >> m_sz[w]))) begin hit = 1; id = m_id[w]; end
      msk = 0;
      if (hit)
        for (int e = 0; e < 16; e++)
          if (m_idm[e][id] && m_typ[e][mt]) msk |= m_way[e];
      s = int'(ma[9:6]);
      if (msk == 0) en = 1;
      else begin
        ev = 1;
        for (int k = 0; k < 32; k++)
          if (ew < 0 && msk[(m_ptr[s] + k) % 32]) ew = (m_ptr[s] + k) % 32;
        m_ptr[s] = (ew + 1) % 32;
      end
    end
    if (we) begin
      if (ca[6]) begin
        if (ca[1:0] == 0) m_base[ca[4:2]] = cd;
        else if (ca[1:0] == 1) begin
          m_en[ca[4:2]] = cd[31]; m_sz[ca[4:2]] = int'(cd[12:8]); m_id[ca[4:2]] = int'(cd[4:0]);
        end
      end else begin
        if (ca[1:0] == 0) m_idm[ca[5:2]] = cd;
        else if (ca[1:0] == 1) m_typ[ca[5:2]] = cd[7:0];
        else if (ca[1:0] == 2) m_way[ca[5:2]] = cd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we_i = 0; miss_valid_i = 0;
    tests++;
    if (victim_valid_o !== ev || no_alloc_o !== en || (ev && victim_way_o !== 5'(ew))) begin
      fails++;
      $display("FAIL %s: actual v=%0b way=%0d na=%0b expected v=%0b way=%0d na=%0b",
               tag, victim_valid_o, victim_way_o, no_alloc_o, ev, ew, en);
    end
  endtask

  task automatic wr(string tag, bit [6:0] a, bit [31:0] d);
    cyc(tag, 1, a, d, 0, 0, 0);
  endtask
  task automatic miss(string tag, bit [31:0] a, bit [2:0] t);
    cyc(tag, 0, 0, 0, 1, a, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    tests++;
    if (victim_valid_o !== 0 || no_alloc_o !== 0) begin
      fails++;
      $display("FAIL R9 reset: actual v=%0b na=%0b expected 0 0", victim_valid_o, no_alloc_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    cyc("R9_idle", 0, 0, 0, 0, 0, 0);
    miss("R1_no_window_after_reset", 32'h0000_0040, 0);
    miss("R4_no_window", 32'h1234_5680, 3);
    // windows: 0 covers 0x0000_0000 size 2^28 id 3; 1 covers 0x1000_0000 id 7;
    // 2 covers 0x0000_0000 size 2^30 id 9 (overlaps 0)
    wr("R10_cfg", wa(0, 0), 32'h0000_0000);
    wr("R10_cfg", wa(0, 1), wctrl(1, 28, 3));
    wr("R10_cfg", wa(1, 0), 32'h1000_0000);
    wr("R10_cfg", wa(1, 1), wctrl(1, 28, 7));
    wr("R10_cfg", wa(2, 0), 32'h0000_0000);
    wr("R10_cfg", wa(2, 1), wctrl(1, 30, 9));
    for (int i = 0; i < 3; i++) miss("R11_default_all_ways", 32'h0000_0080, 0);
    miss("R8_other_set_starts_at_0", 32'h0000_00C0, 5);
    miss("R2_window_match_high", 32'h1FFF_FFC0, 2);
    miss("R4_outside_all", 32'h8000_0000, 0);
    // partition table
    for (int e = 0; e < 16; e++) wr("R10_cfg", pa(e, 0), 32'h0);
    miss("R7_all_id_masks_zero", 32'h0000_0100, 0);
    wr("R10_cfg", pa(0, 0), 32'h0000_0008);
    wr("R10_cfg", pa(0, 1), 32'h0000_0001);
    wr("R10_cfg", pa(0, 2), 32'h0000_000F);
    wr("R10_cfg", pa(1, 0), 32'h0000_0080);
    wr("R10_cfg", pa(1, 2), 32'h0000_00F0);
    wr("R10_cfg", pa(2, 0), 32'h0000_0008);
    wr("R10_cfg", pa(2, 1), 32'h0000_0002);
    wr("R10_cfg", pa(2, 2), 32'hF000_0000);
    wr("R10_cfg", pa(4, 0), 32'h0000_0200);
    wr("R10_cfg", pa(4, 2), 32'h0001_0000);
    wr("R10_reserved_field_ignored", pa(5, 3), 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) miss("R5_type0_ways0_3", 32'h0000_0140, 0);
    for (int i = 0; i < 5; i++) miss("R8_type1_wrap_28_31", 32'h0000_0180, 1);
    miss("R7_type_not_admitted", 32'h0000_01C0, 2);
    for (int i = 0; i < 5; i++) miss("R5_id7_ways4_7", 32'h1000_0200, 6);
    miss("R3_overlap_low_window_wins", 32'h0100_0240, 0);
    miss("R3_only_window2", 32'h2000_0240, 0);
    wr("R10_cfg", pa(3, 0), 32'h0000_0008);
    wr("R10_cfg", pa(3, 1), 32'h0000_0001);
    wr("R10_cfg", pa(3, 2), 32'h8000_0100);
    for (int i = 0; i < 6; i++) miss("R6_or_of_masks", 32'h0000_0280, 0);
    // write in same cycle as miss: miss uses old mask
    cyc("R10_same_cycle_old_cfg", 1, pa(0, 2), 32'h0000_0C00, 1, 32'h0000_02C0, 0);
    miss("R10_new_cfg_next", 32'h0000_02C0, 0);
    cyc("R10_window_disable_same_cycle", 1, wa(1, 1), wctrl(0, 28, 7), 1, 32'h1000_0300, 0);
    miss("R4_window_disabled", 32'h1000_0300, 0);
    // mixed phase
    for (int i = 0; i < 400; i++) begin
      bit [31:0] r = $urandom;
      bit [31:0] ad = {2'b00, r[3] ? 2'b01 : 2'b00, 18'h0, r[9:6], 6'h0};
      if (r[20:18] == 0) cyc("R6_mixed", 1, pa(int'(r[23:22]), int'(r[25:24]) % 3),
                             $urandom & $urandom, 1, ad, r[30:28]);
      else cyc("R8_mixed", 0, 0, 0, r[31] | r[27], ad, r[30:28]);
    end
    // reset mid-run restores defaults
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk);
    miss("R1_after_rereset", 32'h0000_0000, 0);
    wr("R10_cfg", wa(0, 1), wctrl(1, 31, 0));
    miss("R11_defaults_after_rereset", 32'h0000_0000, 7);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule